// File: doc/BRIEF.md
# Mains-Cycle BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar from the power line instead of a crystal. Every cycle of the mains waveform arrives as a single-clock pulse on `line_pulse`. A prescaler divides these pulses by the selected line rate, 60 or 50 cycles per second, and produces a tenths-of-a-second digit and whole seconds. The seconds feed minutes, hours, day of week, date, month and a two-digit year. Every field is kept in packed BCD.

Software reaches the eight time fields through a small register port: a 3-bit slot address, a write strobe, write data and a combinational read-data bus. Writes take effect only while the `wr_gate` input is high. After power-up the counter stays halted and `pwr_fail` stays raised until software completes one accepted write. That write also restarts the sub-second phase, so the first full second ends exactly one second after the write.

A one-cycle `sec_strobe` marks every seconds increment. Alarm and daylight-saving logic nearby can use it without decoding the time fields.

Top module: `mains_bcd_calendar`

## Requirements
- R1: With `sel_50`=0 the tenths digit advances once every 6 line pulses and seconds once every 60. With `sel_50`=1 these become every 5 and every 50 pulses.
- R2: Slot 7 reads the tenths digit (0 to 9) in bits 3:0, with zero in bits 7:4. A write to slot 7 changes no field. Any accepted write to any slot clears the tenths digit and the pulse phase to zero.
- R3: Slot 0 (seconds) and slot 1 (minutes) count BCD 00 to 59. Each wraps to 00 and carries one into the next field.
- R4: When hour bit 7 is 1 (24-hour mode), bits 5:0 count BCD 00 to 23. The step from 23 to 00 advances the day.
- R5: When hour bit 7 is 0 (12-hour mode), bits 4:0 hold BCD 01 to 12 and bit 5 set means PM. The order is 12 AM, 1 to 11 AM, 12 PM, 1 to 11 PM. Bit 5 toggles on the 11-to-12 step, and 11 PM to 12 AM advances the day.
- R6: Slots 3, 4 and 5 hold date (01 to month length), month (01 to 12) and year (00 to 99). April, June, September and November have 30 days and the other months have 31. February has 29 days when the year is divisible by 4, including 00, and 28 otherwise. December 31 rolls to January 1 and increments the year, and year 99 wraps to 00.
- R7: Slot 6 (day of week) steps 0 to 6 and back to 0 on each day advance.
- R8: After reset no field changes, whatever pulses arrive, until an accepted write occurs.
- R9: A write strobe with `wr_gate` low changes no field, no flag and no run state.
- R10: `pwr_fail` is 1 after reset and drops to 0 on the first accepted write. Nothing sets it again except reset.
- R11: Reset values are 00 for seconds, minutes, hour, year, day of week and tenths, and 01 for date and month. Reset selects 12-hour AM.
- R12: `sec_strobe` is high for exactly one cycle on each seconds increment, in the same cycle the new seconds value first reads back.
- R13: Unused bits are dropped on write and read as 0. Seconds and minutes keep bits 6:0, hour keeps bits 7 and 5:0, date keeps bits 5:0, month keeps bits 4:0, day of week keeps bits 2:0, and year keeps all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| line_pulse | input | 1 | One-clock pulse per mains cycle |
| sel_50 | input | 1 | 0: 60 pulses per second, 1: 50 pulses per second |
| wr_gate | input | 1 | Write permission for the time registers |
| addr | input | 3 | Slot select: 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year, 6 day of week, 7 tenths |
| wr_stb | input | 1 | Write strobe for the addressed slot |
| wr_data | input | 8 | Write data, packed BCD |
| rd_data | output | 8 | Combinational read of the addressed slot |
| pwr_fail | output | 1 | Set by reset, cleared by the first accepted write |
| sec_strobe | output | 1 | One-cycle pulse on each seconds increment |

## Verification
The hardest conditions to reach are the rare rollovers: year end, the leap-day boundary, the 12-hour noon and midnight steps, and the end of a short month. Reaching any of them by counting up from reset would take millions of cycles. The bench therefore writes a time one second before each boundary and then supplies exactly one second of line pulses. A behavioural model tracks every pulse, so each rollover is checked cycle by cycle, including runs with sparse pulses and at the 50-cycle rate.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

   typedef enum logic [2:0] {
      SLOT_SEC   = 3'd0,
      SLOT_MIN   = 3'd1,
      SLOT_HOUR  = 3'd2,
      SLOT_DATE  = 3'd3,
      SLOT_MON   = 3'd4,
      SLOT_YEAR  = 3'd5,
      SLOT_DOW   = 3'd6,
      SLOT_TENTH = 3'd7
   } slot_e;

   localparam logic [7:0] KEEP_SEC  = 8'h7F;
   localparam logic [7:0] KEEP_HOUR = 8'hBF;
   localparam logic [7:0] KEEP_DATE = 8'h3F;
   localparam logic [7:0] KEEP_MON  = 8'h1F;
   localparam logic [7:0] KEEP_YEAR = 8'hFF;
   localparam logic [7:0] KEEP_DOW  = 8'h07;

   // advance a packed two-digit BCD value by one
   function automatic logic [7:0] bcd_step(input logic [7:0] v);
      logic [7:0] r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // last day of a BCD month; leap test is year mod 4 on the BCD digits
   function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
      logic [1:0] rem;
      logic [7:0] r;
      rem = yr[1:0] + {yr[4], 1'b0};
      case (mon)
         8'h02:                      r = (rem == 2'd0) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/mbc_prescale.sv
module mbc_prescale
   import mbc_pkg::*;
#(
   parameter int RATE_HI = 60,
   parameter int RATE_LO = 50,
   parameter int STEPS   = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       restart,
   input  logic                       run,
   input  logic                       line_pulse,
   input  logic                       sel_lo,
   output logic [$clog2(STEPS)-1:0]   tenths,
   output logic                       sec_adv
);

   localparam int DIV_HI  = RATE_HI / STEPS;
   localparam int DIV_LO  = RATE_LO / STEPS;
   localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
   localparam int CW      = $clog2(DIV_MAX + 1);
   localparam int TW      = $clog2(STEPS);

   generate
      if ((RATE_HI % STEPS) != 0 || (RATE_LO % STEPS) != 0) begin : g_bad_rate
         $error("line rates must be whole multiples of the sub-second step count");
      end
      if (DIV_HI < 1 || DIV_LO < 1) begin : g_bad_div
         $error("line rate below one pulse per sub-second step");
      end
   endgenerate

   logic [CW-1:0] pre_q;
   logic [CW-1:0] div_last;

   generate
      if (DIV_HI == DIV_LO) begin : g_single_rate
         assign div_last = CW'(DIV_HI - 1);
      end else begin : g_dual_rate
         assign div_last = sel_lo ? CW'(DIV_LO - 1) : CW'(DIV_HI - 1);
      end
   endgenerate

   logic step_ok;
   logic step_end;

   assign step_ok  = run && line_pulse && !restart;
   assign step_end = step_ok && (pre_q >= div_last);
   assign sec_adv  = step_end && (tenths >= TW'(STEPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         tenths <= '0;
      end else if (restart) begin
         pre_q  <= '0;
         tenths <= '0;
      end else if (step_ok) begin
         if (step_end) begin
            pre_q  <= '0;
            tenths <= sec_adv ? '0 : tenths + TW'(1);
         end else begin
            pre_q  <= pre_q + CW'(1);
         end
      end
   end

   // R2
   tenth_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tenths <= TW'(STEPS - 1));

   // R2
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (tenths == '0));

endmodule

// File: rtl/mbc_wrap_ctr.sv
module mbc_wrap_ctr
   import mbc_pkg::*;
#(
   parameter logic [7:0] FIRST = 8'h00,
   parameter logic [7:0] LAST  = 8'h59,
   parameter logic [7:0] RSTV  = 8'h00,
   parameter logic [7:0] KEEP  = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld,
   input  logic [7:0] ld_val,
   input  logic       inc,
   output logic [7:0] q,
   output logic       wrap
);

   generate
      if (LAST < FIRST) begin : g_bad_span
         $error("counter span is empty");
      end
   endgenerate

   assign wrap = inc && (q >= LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RSTV;
      else if (ld)  q <= ld_val & KEEP;
      else if (inc) q <= wrap ? FIRST : bcd_step(q);
   end

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !inc) |=> $stable(q));

endmodule

// File: rtl/mbc_hour.sv
module mbc_hour
   import mbc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld,
   input  logic [7:0] ld_val,
   input  logic       inc,
   output logic [7:0] q,
   output logic       day_carry
);

   logic [7:0] nxt;
   logic       carry_c;
   logic [7:0] step24;
   logic [7:0] step12;

   assign step24 = bcd_step({2'b00, q[5:0]});
   assign step12 = bcd_step({3'b000, q[4:0]});

   always_comb begin
      nxt     = q;
      carry_c = 1'b0;
      if (q[7]) begin
         if (q[5:0] >= 6'h23) begin
            nxt     = 8'h80;
            carry_c = 1'b1;
         end else begin
            nxt = {2'b10, step24[5:0]};
         end
      end else begin
         if (q[4:0] == 5'h11) begin
            nxt     = {2'b00, ~q[5], 5'h12};
            carry_c = q[5];
         end else if (q[4:0] >= 5'h12) begin
            nxt = {2'b00, q[5], 5'h01};
         end else begin
            nxt = {2'b00, q[5], step12[4:0]};
         end
      end
   end

   assign day_carry = inc && carry_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 8'h00;
      else if (ld)  q <= ld_val & KEEP_HOUR;
      else if (inc) q <= nxt;
   end

   // R5
   noon_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && !q[7] && q[4:0] == 5'h11) |=> (q[5] != $past(q[5])));

   // R4
   midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (day_carry && !ld && q[7]) |=> (q == 8'h80));

endmodule

// File: rtl/mbc_calendar.sv
module mbc_calendar
   import mbc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld_date,
   input  logic       ld_mon,
   input  logic [7:0] ld_val,
   input  logic       inc,
   input  logic [7:0] year,
   output logic [7:0] date,
   output logic [7:0] month,
   output logic       year_inc
);

   logic [7:0] len;
   logic       date_end;
   logic       mon_end;

   assign len      = month_days(month, year);
   assign date_end = date >= len;
   assign mon_end  = month >= 8'h12;
   assign year_inc = inc && date_end && mon_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         date  <= 8'h01;
         month <= 8'h01;
      end else begin
         if (ld_date)  date <= ld_val & KEEP_DATE;
         else if (inc) date <= date_end ? 8'h01 : bcd_step(date);

         if (ld_mon)                  month <= ld_val & KEEP_MON;
         else if (inc && date_end)    month <= mon_end ? 8'h01 : bcd_step(month);
      end
   end

   // R6
   month_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ld_mon) && !$past(ld_date) && month != $past(month)) |-> (date == 8'h01));

endmodule

// File: rtl/mains_bcd_calendar.sv
module mains_bcd_calendar
   import mbc_pkg::*;
#(
   parameter int RATE_HI = 60,
   parameter int RATE_LO = 50,
   parameter int STEPS   = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_pulse,
   input  logic       sel_50,
   input  logic       wr_gate,
   input  logic [2:0] addr,
   input  logic       wr_stb,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   output logic       pwr_fail,
   output logic       sec_strobe
);

   localparam int TW     = $clog2(STEPS);
   localparam int NCHAIN = 2;

   generate
      if (STEPS < 2 || STEPS > 10) begin : g_bad_steps
         $error("sub-second digit must fit one BCD digit");
      end
   endgenerate

   logic          accept;
   logic          running;
   logic          sec_adv;
   logic [TW-1:0] tenths;
   logic [7:0]    chain_q [NCHAIN];
   logic          chain_c [NCHAIN+1];
   logic [7:0]    hour_q;
   logic          day_adv;
   logic [7:0]    date_q;
   logic [7:0]    mon_q;
   logic [7:0]    year_q;
   logic          year_adv;
   logic [7:0]    dow_q;
   logic          dow_wrap;
   logic          year_wrap;

   assign accept = wr_stb && wr_gate;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running    <= 1'b0;
         pwr_fail   <= 1'b1;
         sec_strobe <= 1'b0;
      end else begin
         sec_strobe <= sec_adv;
         if (accept) begin
            running  <= 1'b1;
            pwr_fail <= 1'b0;
         end
      end
   end

   mbc_prescale #(.RATE_HI(RATE_HI), .RATE_LO(RATE_LO), .STEPS(STEPS)) u_pre (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (accept),
      .run        (running),
      .line_pulse (line_pulse),
      .sel_lo     (sel_50),
      .tenths     (tenths),
      .sec_adv    (sec_adv)
   );

   assign chain_c[0] = sec_adv;

   for (genvar gi = 0; gi < NCHAIN; gi++) begin : g_chain
      mbc_wrap_ctr #(.FIRST(8'h00), .LAST(8'h59), .RSTV(8'h00), .KEEP(KEEP_SEC)) u_ctr (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld     (accept && (addr == 3'(gi))),
         .ld_val (wr_data),
         .inc    (chain_c[gi]),
         .q      (chain_q[gi]),
         .wrap   (chain_c[gi+1])
      );
   end

   mbc_hour u_hour (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (accept && slot_e'(addr) == SLOT_HOUR),
      .ld_val    (wr_data),
      .inc       (chain_c[NCHAIN]),
      .q         (hour_q),
      .day_carry (day_adv)
   );

   mbc_calendar u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_date  (accept && slot_e'(addr) == SLOT_DATE),
      .ld_mon   (accept && slot_e'(addr) == SLOT_MON),
      .ld_val   (wr_data),
      .inc      (day_adv),
      .year     (year_q),
      .date     (date_q),
      .month    (mon_q),
      .year_inc (year_adv)
   );

   mbc_wrap_ctr #(.FIRST(8'h00), .LAST(8'h99), .RSTV(8'h00), .KEEP(KEEP_YEAR)) u_year (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (accept && slot_e'(addr) == SLOT_YEAR),
      .ld_val (wr_data),
      .inc    (year_adv),
      .q      (year_q),
      .wrap   (year_wrap)
   );

   mbc_wrap_ctr #(.FIRST(8'h00), .LAST(8'h06), .RSTV(8'h00), .KEEP(KEEP_DOW)) u_dow (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (accept && slot_e'(addr) == SLOT_DOW),
      .ld_val (wr_data),
      .inc    (day_adv),
      .q      (dow_q),
      .wrap   (dow_wrap)
   );

   always_comb begin
      case (slot_e'(addr))
         SLOT_SEC:   rd_data = chain_q[0];
         SLOT_MIN:   rd_data = chain_q[1];
         SLOT_HOUR:  rd_data = hour_q;
         SLOT_DATE:  rd_data = date_q;
         SLOT_MON:   rd_data = mon_q;
         SLOT_YEAR:  rd_data = year_q;
         SLOT_DOW:   rd_data = dow_q;
         default:    rd_data = {{(8-TW){1'b0}}, tenths};
      endcase
   end

   // R8
   halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !accept) |=> ($stable(chain_q[0]) && $stable(tenths) && $stable(date_q)));

   // R9
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !wr_gate && !running) |=> (!running && $stable(pwr_fail)));

   // R10
   fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_fail |=> !pwr_fail);

   // R12
   strobe_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_strobe |-> (chain_q[0] != $past(chain_q[0])));

   // R12
   strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_strobe |=> !sec_strobe);

   // R7
   dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(accept) && dow_q != $past(dow_q)) |-> $past(day_adv));

endmodule

// File: tb/tb_mains_bcd_calendar.sv
`timescale 1ns/1ps
module tb_mains_bcd_calendar;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_pulse = 1'b0;
   logic       sel_50 = 1'b0;
   logic       wr_gate = 1'b0;
   logic [2:0] addr = 3'd0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       pwr_fail;
   logic       sec_strobe;

   always #2.5 clk = ~clk;

   mains_bcd_calendar dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_pulse (line_pulse),
      .sel_50     (sel_50),
      .wr_gate    (wr_gate),
      .addr       (addr),
      .wr_stb     (wr_stb),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .pwr_fail   (pwr_fail),
      .sec_strobe (sec_strobe)
   );

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;
   bit started  = 1'b0;
   int pulse_every = 1;
   int phase = 0;
   int rr = 0;

   // behavioural reference state (binary integers)
   int  m_sc, m_mn, m_hr, m_pm, m_mil, m_dt, m_mo, m_yr, m_dw, m_ss, m_pre;
   bit  m_run, m_fail, m_strobe;

   function automatic int b2i(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int mlen(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic model_reset();
      m_sc = 0; m_mn = 0; m_hr = 0; m_pm = 0; m_mil = 0;
      m_dt = 1; m_mo = 1; m_yr = 0; m_dw = 0; m_ss = 0; m_pre = 0;
      m_run = 0; m_fail = 1; m_strobe = 0;
   endtask

   task automatic model_day();
      m_dw = (m_dw + 1) % 7;
      if (m_dt >= mlen(m_mo, m_yr)) begin
         m_dt = 1;
         if (m_mo >= 12) begin
            m_mo = 1;
            m_yr = (m_yr + 1) % 100;
         end else m_mo++;
      end else m_dt++;
   endtask

   task automatic model_second();
      m_sc++;
      if (m_sc < 60) return;
      m_sc = 0; m_mn++;
      if (m_mn < 60) return;
      m_mn = 0;
      if (m_mil != 0) begin
         m_hr++;
         if (m_hr >= 24) begin m_hr = 0; model_day(); end
      end else begin
         if (m_hr == 11) begin
            m_hr = 12;
            if (m_pm != 0) begin m_pm = 0; model_day(); end
            else m_pm = 1;
         end else if (m_hr >= 12) m_hr = 1;
         else m_hr++;
      end
   endtask

   task automatic model_load(input logic [2:0] a, input logic [7:0] d);
      logic [7:0] h;
      case (a)
         3'd0: m_sc = b2i(d & 8'h7F);
         3'd1: m_mn = b2i(d & 8'h7F);
         3'd2: begin
            h = d & 8'hBF;
            m_mil = int'(h[7]);
            if (h[7]) m_hr = b2i({2'b00, h[5:0]});
            else begin m_hr = b2i({3'b000, h[4:0]}); m_pm = int'(h[5]); end
         end
         3'd3: m_dt = b2i(d & 8'h3F);
         3'd4: m_mo = b2i(d & 8'h1F);
         3'd5: m_yr = b2i(d);
         3'd6: m_dw = b2i(d & 8'h07);
         default: ;
      endcase
   endtask

   function automatic logic [7:0] exp_reg(input logic [2:0] a);
      case (a)
         3'd0: return i2b(m_sc);
         3'd1: return i2b(m_mn);
         3'd2: return (m_mil != 0) ? (8'h80 | i2b(m_hr))
                                   : (((m_pm != 0) ? 8'h20 : 8'h00) | i2b(m_hr));
         3'd3: return i2b(m_dt);
         3'd4: return i2b(m_mo);
         3'd5: return i2b(m_yr);
         3'd6: return i2b(m_dw);
         default: return 8'(m_ss);
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] a);
      case (a)
         3'd0, 3'd1:       return "R3";
         3'd2:             return "R5";
         3'd3, 3'd4, 3'd5: return "R6";
         3'd6:             return "R7";
         default:          return "R2";
      endcase
   endfunction

   initial model_reset();

   always @(posedge clk) begin
      int div;
      if (!rst_n) begin
         model_reset();
         started = 1'b1;
      end else begin
         m_strobe = 0;
         if (wr_stb && wr_gate) begin
            m_fail = 0; m_run = 1; m_ss = 0; m_pre = 0;
            model_load(addr, wr_data);
         end else if (m_run && line_pulse) begin
            div = sel_50 ? 5 : 6;
            if (m_pre >= div - 1) begin
               m_pre = 0;
               if (m_ss == 9) begin
                  m_ss = 0;
                  model_second();
                  m_strobe = 1;
               end else m_ss++;
            end else m_pre++;
         end
      end
   end

   task automatic cmp(input string tag, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      #1;
      if (started && rst_n && !finished) begin
         cmp(tag_of(addr), rd_data, exp_reg(addr));
         cmp("R10", {7'd0, pwr_fail}, {7'd0, m_fail});
         cmp("R12", {7'd0, sec_strobe}, {7'd0, m_strobe});
      end
   end

   task automatic step(input bit stb, input bit pl, input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      line_pulse = pl;
      wr_stb     = stb;
      addr       = stb ? a : 3'(rr % 8);
      wr_data    = d;
      rr++;
   endtask

   task automatic put(input logic [2:0] a, input logic [7:0] d);
      step(1'b1, 1'b0, a, d);
   endtask

   task automatic run_pulses(input int n);
      int got = 0;
      while (got < n) begin
         bit p;
         p = (phase % pulse_every) == 0;
         phase++;
         step(1'b0, p, 3'd0, 8'h00);
         if (p) got++;
      end
   endtask

   task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      line_pulse = 1'b0;
      wr_stb     = 1'b0;
      addr       = a;
      #1 cmp(tag, rd_data, exp);
   endtask

   task automatic peek_flags(input bit exp_fail, input bit exp_strobe, input string tag);
      @(negedge clk);
      line_pulse = 1'b0;
      wr_stb     = 1'b0;
      #1;
      cmp(tag, {6'd0, pwr_fail, sec_strobe}, {6'd0, exp_fail, exp_strobe});
   endtask

   task automatic set_time(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                           input logic [7:0] dw, input logic [7:0] hr, input logic [7:0] mn,
                           input logic [7:0] sc);
      put(3'd5, yr); put(3'd4, mo); put(3'd3, dt); put(3'd6, dw);
      put(3'd2, hr); put(3'd1, mn); put(3'd0, sc);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset values, R10 flag raised
      peek(3'd0, 8'h00, "R11"); peek(3'd2, 8'h00, "R11");
      peek(3'd3, 8'h01, "R11"); peek(3'd4, 8'h01, "R11");
      peek(3'd7, 8'h00, "R11");
      peek_flags(1'b1, 1'b0, "R10");

      // R8 halted: pulses without any write
      run_pulses(130);
      peek(3'd0, 8'h00, "R8"); peek(3'd7, 8'h00, "R8");

      // R9 write with gate low is ignored
      put(3'd0, 8'h30);
      peek(3'd0, 8'h00, "R9");
      run_pulses(70);
      peek(3'd0, 8'h00, "R9");
      peek_flags(1'b1, 1'b0, "R9");

      // R10 first accepted write clears flag and starts counting
      wr_gate = 1'b1;
      put(3'd0, 8'h10);
      peek_flags(1'b0, 1'b0, "R10");
      // R1 60-cycle rate: tenths after 6 pulses, seconds after 60
      run_pulses(6);
      peek(3'd7, 8'h01, "R1");
      run_pulses(53);
      peek(3'd0, 8'h10, "R1");
      peek(3'd7, 8'h09, "R2");
      run_pulses(1);
      peek_flags(1'b0, 1'b1, "R12");
      peek_flags(1'b0, 1'b0, "R12");
      peek(3'd0, 8'h11, "R1");
      peek(3'd7, 8'h00, "R2");

      // R2 mid-second write clears tenths, slot 7 write loads nothing
      run_pulses(30);
      peek(3'd7, 8'h05, "R2");
      put(3'd7, 8'h07);
      peek(3'd7, 8'h00, "R2");
      peek(3'd0, 8'h11, "R2");

      // R1 sparse pulses
      pulse_every = 3; phase = 0;
      run_pulses(60);
      peek(3'd0, 8'h12, "R1");
      pulse_every = 1;

      // R13 unused bits dropped
      put(3'd0, 8'hC5);
      peek(3'd0, 8'h45, "R13");
      put(3'd6, 8'hF3);
      peek(3'd6, 8'h03, "R13");

      // R4 R6 R7 year end in 24-hour mode
      set_time(8'h99, 8'h12, 8'h31, 8'h06, 8'hA3, 8'h59, 8'h59);
      run_pulses(60);
      peek(3'd0, 8'h00, "R3"); peek(3'd1, 8'h00, "R3");
      peek(3'd2, 8'h80, "R4"); peek(3'd3, 8'h01, "R6");
      peek(3'd4, 8'h01, "R6"); peek(3'd5, 8'h00, "R6");
      peek(3'd6, 8'h00, "R7");

      // R6 leap year
      set_time(8'h24, 8'h02, 8'h28, 8'h02, 8'hA3, 8'h59, 8'h59);
      run_pulses(60);
      peek(3'd3, 8'h29, "R6"); peek(3'd4, 8'h02, "R6");
      peek(3'd6, 8'h03, "R7");
      set_time(8'h24, 8'h02, 8'h29, 8'h02, 8'hA3, 8'h59, 8'h59);
      run_pulses(60);
      peek(3'd3, 8'h01, "R6"); peek(3'd4, 8'h03, "R6");
      set_time(8'h23, 8'h02, 8'h28, 8'h02, 8'hA3, 8'h59, 8'h59);
      run_pulses(60);
      peek(3'd3, 8'h01, "R6"); peek(3'd4, 8'h03, "R6");
      set_time(8'h00, 8'h02, 8'h28, 8'h02, 8'hA3, 8'h59, 8'h59);
      run_pulses(60);
      peek(3'd3, 8'h29, "R6");
      set_time(8'h30, 8'h04, 8'h30, 8'h05, 8'hA3, 8'h59, 8'h59);
      run_pulses(60);
      peek(3'd3, 8'h01, "R6"); peek(3'd4, 8'h05, "R6");

      // R5 12-hour sequence
      set_time(8'h10, 8'h06, 8'h15, 8'h01, 8'h11, 8'h59, 8'h59);
      run_pulses(60);
      peek(3'd2, 8'h32, "R5"); peek(3'd3, 8'h15, "R5");
      set_time(8'h10, 8'h06, 8'h15, 8'h01, 8'h32, 8'h59, 8'h59);
      run_pulses(60);
      peek(3'd2, 8'h21, "R5");
      set_time(8'h10, 8'h06, 8'h15, 8'h01, 8'h31, 8'h59, 8'h59);
      run_pulses(60);
      peek(3'd2, 8'h12, "R5"); peek(3'd3, 8'h16, "R5");
      peek(3'd6, 8'h02, "R7");
      set_time(8'h10, 8'h06, 8'h15, 8'h01, 8'h12, 8'h59, 8'h59);
      run_pulses(60);
      peek(3'd2, 8'h01, "R5");

      // R1 50-cycle rate
      sel_50 = 1'b1;
      put(3'd0, 8'h20);
      run_pulses(5);
      peek(3'd7, 8'h01, "R1");
      run_pulses(45);
      peek(3'd0, 8'h21, "R1");
      pulse_every = 2; phase = 0;
      run_pulses(50);
      peek(3'd0, 8'h22, "R1");

      // R9 gate low while running
      wr_gate = 1'b0;
      put(3'd1, 8'h44);
      peek(3'd1, 8'h00, "R9");
      run_pulses(20);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         bad++;
         total++;
         $display("FAIL R8 watchdog: got hang expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule